// File: doc/BRIEF.md
# Branch Delay-Slot Commit Controller

This block sits at the resolve point of a short in-order pipeline whose branches each have exactly one delay slot. Instructions arrive one per cycle with a valid flag. When a valid instruction is a branch or jump, the controller records whether its delay-slot instruction will commit. It also records where fetch must go once the slot has passed. The slot is the next valid instruction.

A per-branch annul bit chooses between two policies. With annul clear, the slot always commits. With annul set, the slot is suppressed on one of the two outcomes. A build-time family parameter picks that outcome:

- The canceling family drops the slot when the branch falls through, which suits a slot filled from the target path.
- The plain family drops the slot when the branch is taken, which suits a slot filled from the fall-through path.

A suppressed slot becomes a bubble. It writes no register, writes no memory and raises no exception. A slot that commits and faults raises its exception with a delay-slot indicator set. The redirect that follows the slot depends only on the resolved outcome.

Top module: `dslot_annul_top`

## Requirements
- R1: After reset no slot is pending. A valid non-branch instruction then commits: its register and memory write requests pass through to `regWrEn`/`memWrEn`, `slotKill` is 0 and `pcLoad` is 0.
- R2: For a branch with `brAnnul`=0, its slot instruction commits (`slotKill`=0) whether the branch is taken or not.
- R3: With `FAMILY`=0 (canceling) and `brAnnul`=1, the slot is killed (`slotKill`=1) exactly when the branch is not taken.
- R4: With `FAMILY`=1 (plain) and `brAnnul`=1, the slot is killed exactly when the branch is taken.
- R5: In a cycle where `slotKill`=1, `regWrEn`, `memWrEn` and `excTake` are all 0, whatever the instruction requests.
- R6: `instFault` on a killed slot is ignored. On a committed slot it gives `excTake`=1 with `excInSlot`=1. On any instruction that is not a slot it gives `excTake`=1 with `excInSlot`=0.
- R7: In the cycle the slot instruction is valid, `pcLoad`=1. `nextPc` is then the branch's `brTarget` if the branch resolved taken and its `brFallPc` otherwise, independent of the kill decision.
- R8: A branch with `brJump`=1 behaves as a taken branch for both the kill decision and the redirect, whatever `brTaken` says.
- R9: Cycles with `instValid`=0 between a branch and its slot keep the slot pending. They give `pcLoad`=0 and `slotKill`=0, and the next valid instruction is treated as the slot.
- R10: Branch fields presented with the slot instruction itself are ignored. The slot does not arm a new slot, so the following valid instruction is not a slot (`pcLoad`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | A valid instruction is at the resolve point this cycle |
| instRegWr | input | 1 | Instruction requests a register write |
| instMemWr | input | 1 | Instruction requests a memory write |
| instFault | input | 1 | Instruction has flagged a possible exception |
| brValid | input | 1 | Instruction is a branch or jump |
| brJump | input | 1 | Branch is an unconditional jump |
| brAnnul | input | 1 | Annul bit from the branch encoding |
| brTaken | input | 1 | Resolved outcome of a conditional branch |
| brTarget | input | AW | Branch target address |
| brFallPc | input | AW | Address following the delay slot |
| slotKill | output | 1 | Current instruction is a slot being squashed |
| regWrEn | output | 1 | Register write enable after squashing |
| memWrEn | output | 1 | Memory write enable after squashing |
| excTake | output | 1 | Exception raised by the current instruction |
| excInSlot | output | 1 | Raised exception belongs to a delay slot |
| pcLoad | output | 1 | Fetch redirect after the slot |
| nextPc | output | AW | Redirect address, valid while pcLoad is 1 |

## Verification
The situations hardest to reach from the ports combine three things: a branch, one or more empty cycles before its slot, and a slot that itself carries branch fields or a fault. Random streams seldom line these up with the right annul and outcome values. The bench therefore mixes a seeded random stream with directed sequences for them. These cover a bubble gap before the slot, a faulting slot under each annul decision, a jump whose taken flag is low, and a branch presented as the slot. Both family variants run side by side on identical stimulus, so each annul interpretation is compared against its own expected model.

// File: rtl/dslot_annul_pkg.sv
package dslot_annul_pkg;

  localparam int FAM_CANCEL = 0;
  localparam int FAM_PLAIN  = 1;

  typedef struct packed {
    logic latchBranch;
    logic isSlot;
    logic killSlot;
    logic takeTarget;
  } ctrlStrobes_t;

endpackage

// File: rtl/dslot_annul_ctrl.sv
module dslot_annul_ctrl
  import dslot_annul_pkg::*;
#(
  parameter int FAMILY = FAM_CANCEL
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic         brValid,
  input  logic         brJump,
  input  logic         brAnnul,
  input  logic         brTaken,
  output ctrlStrobes_t strobes
);

  logic pendValid;
  logic pendKill;
  logic pendTaken;
  logic effTaken;
  logic annulKill;
  logic armBranch;

  // A jump resolves as an always-taken branch.
  assign effTaken  = brJump | brTaken;
  // A branch arms a slot only if it is not itself the slot.
  assign armBranch = instValid & brValid & ~pendValid;

  generate
    if (FAMILY == FAM_PLAIN) begin : g_plain
      assign annulKill = brAnnul & effTaken;
    end else begin : g_cancel
      assign annulKill = brAnnul & ~effTaken;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendKill  <= 1'b0;
      pendTaken <= 1'b0;
    end else if (armBranch) begin
      pendValid <= 1'b1;
      pendKill  <= annulKill;
      pendTaken <= effTaken;
    end else if (instValid && pendValid) begin
      pendValid <= 1'b0;
      pendKill  <= 1'b0;
      pendTaken <= 1'b0;
    end
  end

  always_comb begin
    strobes.latchBranch = armBranch;
    strobes.isSlot      = pendValid;
    strobes.killSlot    = pendKill;
    strobes.takeTarget  = pendTaken;
  end

  AST_ANNUL_CLEAR_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (armBranch && !brAnnul) |=> !strobes.killSlot); // R2
  AST_CANCEL_FAMILY: assert property (@(posedge clk) disable iff (!rstN)
    (FAMILY == FAM_CANCEL && armBranch && brAnnul) |=> (strobes.killSlot == !$past(effTaken))); // R3
  AST_PLAIN_FAMILY: assert property (@(posedge clk) disable iff (!rstN)
    (FAMILY == FAM_PLAIN && armBranch && brAnnul) |=> (strobes.killSlot == $past(effTaken))); // R4
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (armBranch && brJump) |=> strobes.takeTarget); // R8
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !instValid) |=> pendValid); // R9
  AST_NO_NESTED_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && instValid) |=> !pendValid); // R10

endmodule

// File: rtl/dslot_annul_dp.sv
module dslot_annul_dp
  import dslot_annul_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic          instValid,
  input  logic          instRegWr,
  input  logic          instMemWr,
  input  logic          instFault,
  input  logic [AW-1:0] brTarget,
  input  logic [AW-1:0] brFallPc,
  output logic          slotKill,
  output logic          regWrEn,
  output logic          memWrEn,
  output logic          excTake,
  output logic          excInSlot,
  output logic          pcLoad,
  output logic [AW-1:0] nextPc
);

  logic [AW-1:0] tgtQ;
  logic [AW-1:0] fallQ;
  logic          slotHere;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ  <= '0;
      fallQ <= '0;
    end else if (strobes.latchBranch) begin
      tgtQ  <= brTarget;
      fallQ <= brFallPc;
    end
  end

  assign slotHere  = instValid & strobes.isSlot;
  assign slotKill  = slotHere & strobes.killSlot;
  assign regWrEn   = instValid & instRegWr & ~slotKill;
  assign memWrEn   = instValid & instMemWr & ~slotKill;
  assign excTake   = instValid & instFault & ~slotKill;
  assign excInSlot = excTake & strobes.isSlot;
  assign pcLoad    = slotHere;
  assign nextPc    = !slotHere ? '0 : (strobes.takeTarget ? tgtQ : fallQ);

  AST_KILL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    slotKill |-> (!regWrEn && !memWrEn && !excTake)); // R5
  AST_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    excInSlot |-> (excTake && pcLoad)); // R6
  AST_KILL_REDIRECTS: assert property (@(posedge clk) disable iff (!rstN)
    slotKill |-> pcLoad); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.isSlot && !strobes.latchBranch) |=> ($stable(tgtQ) && $stable(fallQ))); // R9

endmodule

// File: rtl/dslot_annul_top.sv
module dslot_annul_top
  import dslot_annul_pkg::*;
#(
  parameter int AW     = 32,
  parameter int FAMILY = FAM_CANCEL
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic          instRegWr,
  input  logic          instMemWr,
  input  logic          instFault,
  input  logic          brValid,
  input  logic          brJump,
  input  logic          brAnnul,
  input  logic          brTaken,
  input  logic [AW-1:0] brTarget,
  input  logic [AW-1:0] brFallPc,
  output logic          slotKill,
  output logic          regWrEn,
  output logic          memWrEn,
  output logic          excTake,
  output logic          excInSlot,
  output logic          pcLoad,
  output logic [AW-1:0] nextPc
);

  ctrlStrobes_t strobes;

  dslot_annul_ctrl #(.FAMILY(FAMILY)) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .brValid(brValid),
    .brJump(brJump), .brAnnul(brAnnul), .brTaken(brTaken), .strobes(strobes)
  );

  dslot_annul_dp #(.AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instValid(instValid),
    .instRegWr(instRegWr), .instMemWr(instMemWr), .instFault(instFault),
    .brTarget(brTarget), .brFallPc(brFallPc), .slotKill(slotKill),
    .regWrEn(regWrEn), .memWrEn(memWrEn), .excTake(excTake),
    .excInSlot(excInSlot), .pcLoad(pcLoad), .nextPc(nextPc)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rstN) |-> !pcLoad); // R1

endmodule

// File: tb/dslot_annul_tb.sv
module dslot_annul_top_tb_top;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 0, instRegWr = 0, instMemWr = 0, instFault = 0;
  logic brValid = 0, brJump = 0, brAnnul = 0, brTaken = 0;
  logic [AW-1:0] brTarget = '0, brFallPc = '0;

  logic kill[2], rw[2], mw[2], ex[2], exs[2], pl[2];
  logic [AW-1:0] np[2];

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  logic mPend[2], mKill[2], mTaken[2], mAnnul[2], mJump[2];
  logic [AW-1:0] mTgt[2], mFall[2];

  always #5 clk = ~clk;

  dslot_annul_top #(.AW(AW), .FAMILY(0)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instRegWr(instRegWr),
    .instMemWr(instMemWr), .instFault(instFault), .brValid(brValid),
    .brJump(brJump), .brAnnul(brAnnul), .brTaken(brTaken), .brTarget(brTarget),
    .brFallPc(brFallPc), .slotKill(kill[0]), .regWrEn(rw[0]), .memWrEn(mw[0]),
    .excTake(ex[0]), .excInSlot(exs[0]), .pcLoad(pl[0]), .nextPc(np[0]));

  dslot_annul_top #(.AW(AW), .FAMILY(1)) dut_plain_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instRegWr(instRegWr),
    .instMemWr(instMemWr), .instFault(instFault), .brValid(brValid),
    .brJump(brJump), .brAnnul(brAnnul), .brTaken(brTaken), .brTarget(brTarget),
    .brFallPc(brFallPc), .slotKill(kill[1]), .regWrEn(rw[1]), .memWrEn(mw[1]),
    .excTake(ex[1]), .excInSlot(exs[1]), .pcLoad(pl[1]), .nextPc(np[1]));

  function automatic logic expKillFn(int fam, logic annul, logic taken, logic jump);
    logic t;
    t = taken | jump;
    if (!annul) return 1'b0;
    return (fam == 1) ? t : !t;
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp, int fam);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s family=%0d act=%0h exp=%0h t=%0t", req, fam, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    for (int f = 0; f < 2; f++) begin
      logic s, k;
      string kTag;
      s = instValid & mPend[f];
      k = s & mKill[f];
      kTag = !mAnnul[f] ? "R2" : (mJump[f] ? "R8" : (f == 1 ? "R4" : "R3"));
      if (!mPend[f] && !instValid) kTag = "R9";
      chk(kTag, kill[f], k, f);
      chk(k ? "R5" : "R1", rw[f], instValid & instRegWr & !k, f);
      chk(k ? "R5" : "R1", mw[f], instValid & instMemWr & !k, f);
      chk("R6", ex[f], instValid & instFault & !k, f);
      chk("R6", exs[f], instValid & instFault & !k & s, f);
      chk(mPend[f] && !instValid ? "R9" : "R10", pl[f], s, f);
      if (s) chk(mJump[f] ? "R8" : "R7", np[f], mTaken[f] ? mTgt[f] : mFall[f], f);
    end
  endtask

  task automatic updModel();
    for (int f = 0; f < 2; f++) begin
      if (instValid) begin
        if (mPend[f]) mPend[f] = 0;
        else if (brValid) begin
          mPend[f]  = 1;
          mKill[f]  = expKillFn(f, brAnnul, brTaken, brJump);
          mTaken[f] = brTaken | brJump;
          mAnnul[f] = brAnnul;
          mJump[f]  = brJump;
          mTgt[f]   = brTarget;
          mFall[f]  = brFallPc;
        end
      end
    end
  endtask

  task automatic issue(logic v, logic rwq, logic mwq, logic flt, logic bv, logic bj,
                       logic ba, logic bt, logic [AW-1:0] tgt, logic [AW-1:0] fall);
    @(negedge clk);
    instValid = v; instRegWr = rwq; instMemWr = mwq; instFault = flt;
    brValid = bv; brJump = bj; brAnnul = ba; brTaken = bt;
    brTarget = tgt; brFallPc = fall;
    #3;
    checkAll();
    updModel();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int f = 0; f < 2; f++) begin
      mPend[f] = 0; mKill[f] = 0; mTaken[f] = 0; mAnnul[f] = 0; mJump[f] = 0;
      mTgt[f] = '0; mFall[f] = '0;
    end
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: plain instruction right after reset
    issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R2: annul clear, taken and not taken
    issue(1, 0, 0, 0, 1, 0, 0, 1, 32'h100, 32'h208);
    issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 1, 0, 0, 0, 32'h300, 32'h408);
    issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3/R4: annul set, both outcomes, faulting slot (R6)
    issue(1, 0, 0, 0, 1, 0, 1, 0, 32'h500, 32'h608);
    issue(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 1, 0, 1, 1, 32'h700, 32'h808);
    issue(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    // R8: jump with taken low, annul set
    issue(1, 0, 0, 0, 1, 1, 1, 0, 32'h900, 32'hA08);
    issue(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R9: bubbles between branch and slot
    issue(1, 0, 0, 0, 1, 0, 1, 1, 32'hB00, 32'hC08);
    issue(0, 1, 1, 1, 1, 0, 0, 0, 32'hDEAD, 32'hBEEF);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R10: slot carries branch fields, next is not a slot
    issue(1, 0, 0, 0, 1, 0, 0, 1, 32'hE00, 32'hF08);
    issue(1, 1, 0, 0, 1, 0, 1, 0, 32'h1234, 32'h5678);
    issue(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    // R6: fault on non-slot instruction
    issue(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      logic v, bv;
      v  = ($urandom % 5) != 0;
      bv = ($urandom % 10) < 3;
      issue(v, 1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0), bv,
            1'(($urandom % 5) == 0), 1'($urandom), 1'($urandom),
            $urandom, $urandom);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule